// File: doc/BRIEF.md
# Segment-Carryover Pointer Adjust Unit

This unit computes the next value of the 8-bit instruction pointer and the 8-bit stack pointer. It also decides whether the paired 8-bit segment register must step, so that each pointer and its segment together behave like a 16-bit address. The instruction pointer is paired with the code segment. The stack pointer is paired with the stack segment. No other segment is ever touched.

Four operations are supported:
- An instruction fetch advances the instruction pointer by a fixed step.
- A push advances the stack pointer by the same step.
- A pop moves the stack pointer back by that step.
- A relative adjust adds a signed two's-complement operand to any register chosen by its register number.

When the pointer leaves its 256-byte window in either direction and carryover is enabled for that pair, the unit requests a segment write of the segment plus or minus one. Two carryover enable flags, one per pair, are held inside the unit. Dedicated configuration commands set or clear them.

The pointer and segment results and their write enables are combinational from the inputs and the stored flags. The owner of the register file applies them at its next clock edge.

Top module: `ptr_carry_unit`

## Requirements
- R1: `op_kind` 2'b00 (fetch) targets the instruction pointer. It gives `ptr_out` = `ptr_in` + 2 modulo 256 and raises `ptr_we`.
- R2: `op_kind` 2'b01 (push) gives `ptr_out` = `ptr_in` + 2. `op_kind` 2'b10 (pop) gives `ptr_out` = `ptr_in` − 2. Both target the stack pointer (`seg_sel` = 1).
- R3: `op_kind` 2'b11 (relative) adds `offset_in` as a signed two's-complement value to `ptr_in`; for example, 50 with offset 0xF6 gives 40.
- R4: When a forward move wraps the pointer past 255 and carryover is enabled for the pair, `seg_out` = `seg_in` + 1 and `seg_we` = 1. `seg_sel` is 0 for the code segment and 1 for the stack segment.
- R5: When a backward move (pop, or relative with a negative offset) borrows below zero and carryover is enabled for the pair, `seg_out` = `seg_in` − 1 and `seg_we` = 1.
- R6: With the pair's carryover flag clear, the pointer still wraps modulo 256 and `seg_we` stays 0.
- R7: A relative adjust whose `tgt_sel` is neither 7 (instruction pointer) nor 6 (stack pointer) is a plain 8-bit add and never raises `seg_we`.
- R8: After reset, carryover is enabled for the code segment pair and disabled for the stack segment pair.
- R9: A command with `cfg_valid` = 1 writes `cfg_enable` into the flag picked by `cfg_stack` (0 = code pair, 1 = stack pair). The new value takes effect from the next cycle. An operation in the same cycle uses the old value.
- R10: With `op_valid` = 0, both `ptr_we` and `seg_we` are 0.
- R11: `seg_we` is raised only when the pointer actually crosses the 0/255 boundary; for example, 0x80 with offset −128 gives 0x00 and no segment step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An adjust operation is presented this cycle |
| op_kind | input | 2 | 00 fetch, 01 push, 10 pop, 11 relative |
| tgt_sel | input | 3 | Register number for a relative adjust (6 = SP, 7 = IP) |
| ptr_in | input | 8 | Current value of the targeted register |
| seg_in | input | 8 | Current value of the paired segment register |
| offset_in | input | 8 | Signed operand of a relative adjust |
| cfg_valid | input | 1 | Carryover flag write command |
| cfg_stack | input | 1 | Flag chosen by the command: 0 code pair, 1 stack pair |
| cfg_enable | input | 1 | Value written into the chosen flag |
| ptr_out | output | 8 | New pointer value |
| ptr_we | output | 1 | Pointer write enable |
| seg_out | output | 8 | New segment value |
| seg_we | output | 1 | Segment write enable |
| seg_sel | output | 1 | Segment written: 0 code, 1 stack |

## Verification
A flag command and a pointer operation can arrive in the same cycle. The crossing operation must then be judged against the flag value stored before the command. The bench enables the stack-pair flag in the same cycle as a pop that borrows from 0x00. It expects no segment write in that cycle. It then repeats the pop in the following cycle and expects `seg_out` = `seg_in` − 1 with `seg_we` raised.

// File: rtl/ptradj_pkg.sv
// Shared types for the pointer adjust unit.
// Assumes a two-bit operation code supplied by the decoder.
package ptradj_pkg;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_REL   = 2'd3
    } adj_op_e;

endpackage

// File: rtl/ptradj_adder.sv
// Pointer adder: adds a two's-complement delta to a pointer and reports
// whether the result left the pointer's window (carry on a forward move,
// borrow on a backward move). Assumes delta is already sign-correct in W bits.
module ptradj_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] delta,
    input  logic         backward,
    output logic [W-1:0] result,
    output logic         crossed
);

    logic [W:0] sum_wide;

    // Widened add so the carry out of the top bit is visible.
    always_comb begin
        sum_wide = {1'b0, base} + {1'b0, delta};
        result   = sum_wide[W-1:0];
        crossed  = backward ? ~sum_wide[W] : sum_wide[W];
    end

endmodule

// File: rtl/ptradj_segstep.sv
// Segment stepper: produces the segment value one above or one below the
// input. Assumes segment arithmetic wraps modulo 2**W.
module ptradj_segstep #(
    parameter int W = 8
) (
    input  logic [W-1:0] seg_cur,
    input  logic         step_down,
    output logic [W-1:0] seg_next
);

    localparam logic [W-1:0] ONE = W'(1);

    // Choose increment or decrement of the segment.
    always_comb begin
        seg_next = step_down ? (seg_cur - ONE) : (seg_cur + ONE);
    end

endmodule

// File: rtl/ptradj_flags.sv
// Carryover enable flags: one per pointer/segment pair, written by
// configuration commands. Assumes a synchronous active-low reset.
module ptradj_flags #(
    parameter bit CODE_RESET  = 1'b1,
    parameter bit STACK_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_valid,
    input  logic cfg_stack,
    input  logic cfg_enable,
    output logic code_en,
    output logic stack_en
);

    // Hold and update the two carryover flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_en  <= CODE_RESET;
            stack_en <= STACK_RESET;
        end else if (cfg_valid) begin
            if (cfg_stack) stack_en <= cfg_enable;
            else           code_en  <= cfg_enable;
        end
    end

    // R8
    reset_flags_chk: assert property (@(posedge clk)
        !rst_n |=> (code_en == CODE_RESET) && (stack_en == STACK_RESET));

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(code_en) && $stable(stack_en));

    // R9
    flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> ((cfg_stack ? stack_en : code_en) == $past(cfg_enable)));

endmodule

// File: rtl/ptr_carry_unit.sv
// Pointer adjust unit with segment carryover. Selects the target pointer
// and delta for fetch, push, pop and relative adjust, computes the new
// pointer, and requests a paired segment step when the pointer crosses its
// window and that pair's carryover flag is set.
// Assumes: results are applied by the register file owner at the next edge.
module ptr_carry_unit
    import ptradj_pkg::*;
#(
    parameter int PTR_W    = 8,
    parameter int SEG_W    = 8,
    parameter int SEL_W    = 3,
    parameter int STEP     = 2,
    parameter int IP_INDEX = 7,
    parameter int SP_INDEX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [SEL_W-1:0] tgt_sel,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [SEG_W-1:0] seg_in,
    input  logic [PTR_W-1:0] offset_in,
    input  logic             cfg_valid,
    input  logic             cfg_stack,
    input  logic             cfg_enable,
    output logic [PTR_W-1:0] ptr_out,
    output logic             ptr_we,
    output logic [SEG_W-1:0] seg_out,
    output logic             seg_we,
    output logic             seg_sel
);

    localparam logic [PTR_W-1:0] STEP_FWD = PTR_W'(STEP);
    localparam logic [PTR_W-1:0] STEP_BWD = PTR_W'(0) - PTR_W'(STEP);
    localparam logic [SEL_W-1:0] IP_SEL   = SEL_W'(IP_INDEX);
    localparam logic [SEL_W-1:0] SP_SEL   = SEL_W'(SP_INDEX);

    adj_op_e          op;
    logic             hit_ip;
    logic             hit_sp;
    logic [PTR_W-1:0] delta;
    logic             backward;
    logic             code_en;
    logic             stack_en;
    logic             crossed;
    logic             pair_en;

    assign op = adj_op_e'(op_kind);

    ptradj_flags #(
        .CODE_RESET  (1'b1),
        .STACK_RESET (1'b0)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_stack  (cfg_stack),
        .cfg_enable (cfg_enable),
        .code_en    (code_en),
        .stack_en   (stack_en)
    );

    // Decode operation into target pointer, delta and direction.
    always_comb begin
        hit_ip   = 1'b0;
        hit_sp   = 1'b0;
        delta    = STEP_FWD;
        backward = 1'b0;
        unique case (op)
            OP_FETCH: hit_ip = 1'b1;
            OP_PUSH:  hit_sp = 1'b1;
            OP_POP: begin
                hit_sp   = 1'b1;
                delta    = STEP_BWD;
                backward = 1'b1;
            end
            OP_REL: begin
                hit_ip   = (tgt_sel == IP_SEL);
                hit_sp   = (tgt_sel == SP_SEL);
                delta    = offset_in;
                backward = offset_in[PTR_W-1];
            end
            default: ;
        endcase
    end

    ptradj_adder #(.W(PTR_W)) u_adder (
        .base     (ptr_in),
        .delta    (delta),
        .backward (backward),
        .result   (ptr_out),
        .crossed  (crossed)
    );

    ptradj_segstep #(.W(SEG_W)) u_segstep (
        .seg_cur   (seg_in),
        .step_down (backward),
        .seg_next  (seg_out)
    );

    // Pick the carryover flag belonging to the targeted pair.
    always_comb begin
        pair_en = hit_ip ? code_en : (hit_sp ? stack_en : 1'b0);
    end

    // Drive write enables and segment choice.
    always_comb begin
        ptr_we  = op_valid;
        seg_we  = op_valid && pair_en && crossed;
        seg_sel = hit_sp;
    end

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !ptr_we && !seg_we);

    // R7
    unpaired_no_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_REL && tgt_sel != IP_SEL && tgt_sel != SP_SEL)
        |-> !seg_we);

    // R11
    seg_needs_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_we |-> (((op == OP_POP) || (op == OP_REL && offset_in[PTR_W-1]))
                    ? (ptr_out > ptr_in) : (ptr_out < ptr_in)));

    // R5
    seg_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_we && op == OP_POP) |-> (seg_out == seg_in - SEG_W'(1)));

    // R2
    stack_ops_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_PUSH || op == OP_POP)) |-> seg_sel);

endmodule

// File: tb/ptr_carry_unit_bench.sv
module ptr_carry_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [1:0] op_kind;
    logic [2:0] tgt_sel;
    logic [7:0] ptr_in, seg_in, offset_in;
    logic       cfg_valid, cfg_stack, cfg_enable;
    logic [7:0] ptr_out, seg_out;
    logic       ptr_we, seg_we, seg_sel;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    ptr_carry_unit u_ptr_carry_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .tgt_sel(tgt_sel), .ptr_in(ptr_in), .seg_in(seg_in),
        .offset_in(offset_in), .cfg_valid(cfg_valid), .cfg_stack(cfg_stack),
        .cfg_enable(cfg_enable), .ptr_out(ptr_out), .ptr_we(ptr_we),
        .seg_out(seg_out), .seg_we(seg_we), .seg_sel(seg_sel)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present an operation at the falling edge, settle, leave it applied.
    task automatic apply(logic [1:0] k, logic [2:0] t, logic [7:0] p,
                         logic [7:0] s, logic [7:0] o);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; tgt_sel = t;
        ptr_in = p; seg_in = s; offset_in = o;
        cfg_valid = 1'b0;
        #1;
    endtask

    task automatic set_flag(logic stk, logic en);
        @(negedge clk);
        op_valid = 1'b0; cfg_valid = 1'b1; cfg_stack = stk; cfg_enable = en;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic t_reset;
        apply(2'b00, 3'd0, 8'hFE, 8'h01, 8'h00);
        chk("R8 fetch wrap ptr", ptr_out, 8'h00);
        chk("R8 code carry on", {7'd0, seg_we}, 8'h01);
        chk("R4 code seg inc", seg_out, 8'h02);
        chk("R4 seg_sel code", {7'd0, seg_sel}, 8'h00);
        apply(2'b10, 3'd0, 8'h00, 8'h02, 8'h00);
        chk("R8 stack carry off", {7'd0, seg_we}, 8'h00);
        chk("R6 pop wrap ptr", ptr_out, 8'hFE);
    endtask

    task automatic t_fetch;
        apply(2'b00, 3'd3, 8'h10, 8'h01, 8'h55);
        chk("R1 fetch ptr", ptr_out, 8'h12);
        chk("R1 ptr_we", {7'd0, ptr_we}, 8'h01);
        chk("R11 no cross no seg", {7'd0, seg_we}, 8'h00);
    endtask

    task automatic t_push_pop;
        apply(2'b01, 3'd0, 8'h10, 8'h02, 8'h00);
        chk("R2 push ptr", ptr_out, 8'h12);
        chk("R2 push sel", {7'd0, seg_sel}, 8'h01);
        apply(2'b10, 3'd0, 8'h10, 8'h02, 8'h00);
        chk("R2 pop ptr", ptr_out, 8'h0E);
    endtask

    task automatic t_relative;
        apply(2'b11, 3'd0, 8'd50, 8'h00, 8'hF6);
        chk("R3 rel 50-10", ptr_out, 8'd40);
        chk("R3 rel no seg", {7'd0, seg_we}, 8'h00);
        apply(2'b11, 3'd7, 8'hF0, 8'h05, 8'h20);
        chk("R4 rel ip ptr", ptr_out, 8'h10);
        chk("R4 rel ip seg", seg_out, 8'h06);
        chk("R4 rel ip seg_we", {7'd0, seg_we}, 8'h01);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b10; tgt_sel = 3'd0;
        ptr_in = 8'h00; seg_in = 8'h03; offset_in = 8'h00;
        cfg_valid = 1'b1; cfg_stack = 1'b1; cfg_enable = 1'b1;
        #1;
        chk("R9 old flag used", {7'd0, seg_we}, 8'h00);
        apply(2'b10, 3'd0, 8'h00, 8'h03, 8'h00);
        chk("R9 new flag active", {7'd0, seg_we}, 8'h01);
        chk("R5 pop borrow seg", seg_out, 8'h02);
        chk("R5 pop borrow sel", {7'd0, seg_sel}, 8'h01);
        apply(2'b11, 3'd6, 8'h05, 8'h03, 8'hF0);
        chk("R5 rel sp ptr", ptr_out, 8'hF5);
        chk("R5 rel sp seg", seg_out, 8'h02);
        chk("R5 rel sp seg_we", {7'd0, seg_we}, 8'h01);
    endtask

    task automatic t_flag_clear;
        set_flag(1'b0, 1'b0);
        apply(2'b00, 3'd0, 8'hFE, 8'h01, 8'h00);
        chk("R6 fetch wrap ptr", ptr_out, 8'h00);
        chk("R6 code off no seg", {7'd0, seg_we}, 8'h00);
        set_flag(1'b0, 1'b1);
        apply(2'b11, 3'd7, 8'h80, 8'h09, 8'h80);
        chk("R11 exact zero ptr", ptr_out, 8'h00);
        chk("R11 exact zero no seg", {7'd0, seg_we}, 8'h00);
        apply(2'b11, 3'd7, 8'h7F, 8'h09, 8'h80);
        chk("R5 ip borrow ptr", ptr_out, 8'hFF);
        chk("R5 ip borrow seg", seg_out, 8'h08);
        chk("R5 ip borrow seg_we", {7'd0, seg_we}, 8'h01);
    endtask

    task automatic t_unpaired;
        apply(2'b11, 3'd2, 8'hFF, 8'h04, 8'h01);
        chk("R7 plain wrap ptr", ptr_out, 8'h00);
        chk("R7 plain no seg", {7'd0, seg_we}, 8'h00);
        apply(2'b11, 3'd3, 8'h00, 8'h04, 8'hFF);
        chk("R7 plain borrow ptr", ptr_out, 8'hFF);
        chk("R7 plain borrow no seg", {7'd0, seg_we}, 8'h00);
    endtask

    task automatic t_idle;
        apply(2'b00, 3'd0, 8'hFE, 8'h01, 8'h00);
        op_valid = 1'b0;
        #1;
        chk("R10 idle ptr_we", {7'd0, ptr_we}, 8'h00);
        chk("R10 idle seg_we", {7'd0, seg_we}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'b00; tgt_sel = 3'd0;
        ptr_in = 8'h00; seg_in = 8'h00; offset_in = 8'h00;
        cfg_valid = 1'b0; cfg_stack = 1'b0; cfg_enable = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fetch();
        t_push_pop();
        t_relative();
        t_same_cycle();
        t_flag_clear();
        t_unpaired();
        t_idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule